// File: doc/BRIEF.md
# Segmented Bus Crosspoint Controller

This block sits at one boundary of a one-dimensional segmented bus, beside the module that occupies slot `MY_ID`. It reserves, keeps and frees data channels between neighbouring segments. Four commands drive it: REQUEST, REPLY, CANCEL and DESTROY. Commands come from the crosspoint on the left, the crosspoint on the right and the local module. Each source has its own small command FIFO, and an arbiter serves the three FIFOs in turn.

A sender opens a connection by handing its crosspoint a REQUEST that names the destination slot. Every crosspoint on the way reserves one outbound lane and passes the REQUEST on. The destination returns a REPLY along the same path. The sender transmits only after that REPLY arrives, and ends the connection with a DESTROY, which frees each reservation as it passes. A crosspoint with no free lane answers CANCEL instead. Reservations made upstream are released as the CANCEL travels back.

Each reserved outbound lane is a register fed from the chosen input lane, so data moves one slot per clock.

Top module: `xp_crosspoint`

## Requirements
- R1: While reset is high and after it falls, no command output is valid, all three `*_cmd_ready` outputs are high, and every lane output and `loc_rx_data` is zero.
- R2: A command word is packed MSB to LSB as {opcode[1:0], source slot, destination slot, channel}. The opcodes are REQUEST=0, REPLY=1, CANCEL=2 and DESTROY=3.
  - A REQUEST whose destination differs from `MY_ID` reserves the lowest free lane on the side toward the destination. That side is the right when the destination is greater than `MY_ID`, otherwise the left.
  - The REQUEST is then sent out on that side, with its channel field replaced by the reserved lane number.
  - The output is valid for one cycle, in the cycle after the clock edge that follows the edge at which the command was written.
- R3: A REQUEST that finds no free lane on its outbound side reserves nothing. It is answered with a CANCEL word (same source, destination and channel) sent toward the source. Toward the source means: left when source < `MY_ID`, right when source > `MY_ID`, and the local output when they are equal.
- R4: A REQUEST whose destination equals `MY_ID` ends here.
  - If no connection already ends here, it is answered with REPLY toward the source, and it records the input side and channel as the local receive lane.
  - If a connection already ends here, it is answered with CANCEL toward the source.
- R5: A REPLY is forwarded unchanged toward its source.
- R6: A CANCEL releases the reservation with matching source and destination on the side toward the destination, then is forwarded unchanged toward the source. The freed lane is available to the next REQUEST.
- R7: A DESTROY whose destination differs from `MY_ID` releases the matching reservation and is forwarded unchanged toward the destination. At the destination it is delivered to the local output and frees the local receive lane.
- R8: When several FIFOs hold commands, one command is taken per cycle. The search starts at the source after the last one served, in the order left, right, local, and wraps around.
- R9: Each reserved outbound lane shows, one clock later, the data of the input lane or local transmit data it was reserved from. An unreserved lane outputs zero.
- R10: `loc_rx_data` shows, one clock later, the input lane recorded at the destination, or zero when none is recorded.
- R11: Each source FIFO holds up to `FIFO_DEPTH` commands. Its ready output is low exactly while it is full. Every command accepted while ready is high produces exactly one command output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lft_cmd_valid | input | 1 | Command from the left crosspoint |
| lft_cmd_word | input | CMD_W | Left command word |
| lft_cmd_ready | output | 1 | Left FIFO not full |
| rgt_cmd_valid | input | 1 | Command from the right crosspoint |
| rgt_cmd_word | input | CMD_W | Right command word |
| rgt_cmd_ready | output | 1 | Right FIFO not full |
| loc_cmd_valid | input | 1 | Command from the local module |
| loc_cmd_word | input | CMD_W | Local command word |
| loc_cmd_ready | output | 1 | Local FIFO not full |
| lft_out_valid | output | 1 | Command to the left crosspoint |
| lft_out_word | output | CMD_W | Word to the left |
| rgt_out_valid | output | 1 | Command to the right crosspoint |
| rgt_out_word | output | CMD_W | Word to the right |
| loc_out_valid | output | 1 | Command to the local module |
| loc_out_word | output | CMD_W | Word to the local module |
| lft_lane_in | input | NCH*DW | Right-going lanes arriving from the left segment |
| rgt_lane_in | input | NCH*DW | Left-going lanes arriving from the right segment |
| loc_tx_data | input | DW | Local transmit data |
| rgt_lane_out | output | NCH*DW | Right-going lanes driven into the right segment |
| lft_lane_out | output | NCH*DW | Left-going lanes driven into the left segment |
| loc_rx_data | output | DW | Data of the connection ending here |

## Verification
The assertions assume reset is applied from time zero. They also assume command words are well formed: slot fields below `NSLOT`, and a DESTROY or CANCEL only for a connection that was requested. Neighbours are assumed to accept an output command in the cycle it is valid, since outputs carry no backpressure. The stimulus writes commands only while the matching ready is high and uses legal slot indices. It issues DESTROY and CANCEL only for pairs it opened earlier, and it changes lane data only at falling edges.

// File: rtl/xp_pkg.sv
`timescale 1ns/1ps
package xp_pkg;
  typedef enum logic [1:0] {
    OP_REQ     = 2'd0,
    OP_REPLY   = 2'd1,
    OP_CANCEL  = 2'd2,
    OP_DESTROY = 2'd3
  } xp_op_e;

  // command side / port code; the numeric order is also the service order
  typedef enum logic [1:0] {
    SIDE_L   = 2'd0,
    SIDE_R   = 2'd1,
    SIDE_LOC = 2'd2
  } xp_side_e;
endpackage

// File: rtl/xp_cmd_fifo.sv
`timescale 1ns/1ps
module xp_cmd_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          do_push, do_pop;

  assign full    = (count == (AW+1)'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_FIFO_FILL_STEP: assert property (@(posedge clk) disable iff (rst)
    (push && !full && !pop) |=> (count == $past(count) + 1'b1)); // R11
  AST_FIFO_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (empty && !push) |=> empty); // R11
endmodule

// File: rtl/xp_rr_arb.sv
`timescale 1ns/1ps
module xp_rr_arb #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int PW = $clog2(N);
  logic [PW-1:0] ptr;

  always_comb begin
    gnt = '0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = int'(ptr) + k;
      if (idx >= N) idx = idx - N;
      if (gnt == '0 && req[idx]) gnt[idx] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else begin
      for (int i = 0; i < N; i++) begin
        if (gnt[i]) ptr <= (i == N-1) ? '0 : PW'(i+1);
      end
    end
  end

  AST_ARB_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt) && ((gnt & ~req) == '0)); // R8
  AST_RR_LEFT_THEN_RIGHT: assert property (@(posedge clk) disable iff (rst)
    gnt[0] |=> (!req[1] || gnt[1])); // R8
  AST_RR_RIGHT_THEN_LOCAL: assert property (@(posedge clk) disable iff (rst)
    gnt[1] |=> (!req[2] || gnt[2])); // R8
  AST_RR_LOCAL_THEN_LEFT: assert property (@(posedge clk) disable iff (rst)
    gnt[2] |=> (!req[0] || gnt[0])); // R8
endmodule

// File: rtl/xp_ctrl.sv
`timescale 1ns/1ps
module xp_ctrl
  import xp_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int NCH   = 4,
  parameter int MY_ID = 3,
  localparam int SW    = $clog2(NSLOT),
  localparam int CW    = $clog2(NCH),
  localparam int CMD_W = 2 + 2*SW + CW
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            in_v,
  input  logic [1:0]                      in_side,
  input  logic [CMD_W-1:0]                in_word,
  output logic                            out_lv,
  output logic [CMD_W-1:0]                out_lw,
  output logic                            out_rv,
  output logic [CMD_W-1:0]                out_rw,
  output logic                            out_cv,
  output logic [CMD_W-1:0]                out_cw,
  output logic [1:0][NCH-1:0]             tab_v,
  output logic [1:0][NCH-1:0][1:0]        tab_side,
  output logic [1:0][NCH-1:0][CW-1:0]     tab_inch,
  output logic                            sink_v,
  output logic [1:0]                      sink_side,
  output logic [CW-1:0]                   sink_ch
);
  localparam logic [SW-1:0] ME = SW'(MY_ID);

  logic [1:0][NCH-1:0][SW-1:0] tab_src, tab_dst;
  logic [SW-1:0] sink_src;

  logic [1:0]    op;
  logic [SW-1:0] src, dst;
  logic [CW-1:0] ch;
  assign op  = in_word[CMD_W-1 -: 2];
  assign src = in_word[CW+SW +: SW];
  assign dst = in_word[CW +: SW];
  assign ch  = in_word[0 +: CW];

  logic          d;        // 0: right-going side, 1: left-going side
  logic [1:0]    back;     // port toward the source
  logic          free_ok, match_ok;
  logic [CW-1:0] free_idx, match_idx;

  assign d    = (dst > ME) ? 1'b0 : 1'b1;
  assign back = (src < ME) ? SIDE_L : ((src > ME) ? SIDE_R : SIDE_LOC);

  always_comb begin
    free_ok = 1'b0; free_idx = '0;
    match_ok = 1'b0; match_idx = '0;
    for (int c = NCH-1; c >= 0; c--) begin
      if (!tab_v[d][c]) begin
        free_ok = 1'b1; free_idx = CW'(c);
      end
      if (tab_v[d][c] && tab_src[d][c] == src && tab_dst[d][c] == dst) begin
        match_ok = 1'b1; match_idx = CW'(c);
      end
    end
  end

  logic             emit_v;
  logic [1:0]       emit_port;
  logic [CMD_W-1:0] emit_word;
  logic             alloc_we, rel_we, sink_set, sink_clr;

  always_comb begin
    emit_v    = 1'b0;
    emit_port = SIDE_LOC;
    emit_word = in_word;
    alloc_we  = 1'b0;
    rel_we    = 1'b0;
    sink_set  = 1'b0;
    sink_clr  = 1'b0;
    if (in_v) begin
      case (op)
        OP_REQ: begin
          emit_v = 1'b1;
          if (dst == ME) begin
            emit_port = back;
            if (!sink_v) begin
              sink_set  = 1'b1;
              emit_word = {OP_REPLY, in_word[CMD_W-3:0]};
            end else begin
              emit_word = {OP_CANCEL, in_word[CMD_W-3:0]};
            end
          end else if (free_ok) begin
            alloc_we  = 1'b1;
            emit_port = d ? SIDE_L : SIDE_R;
            emit_word = {OP_REQ, src, dst, free_idx};
          end else begin
            emit_port = back;
            emit_word = {OP_CANCEL, in_word[CMD_W-3:0]};
          end
        end
        OP_REPLY: begin
          emit_v    = 1'b1;
          emit_port = back;
        end
        OP_CANCEL: begin
          emit_v    = 1'b1;
          emit_port = back;
          rel_we    = (dst != ME) && match_ok;
        end
        default: begin
          emit_v = 1'b1;
          if (dst == ME) begin
            emit_port = SIDE_LOC;
            sink_clr  = sink_v && (sink_src == src);
          end else begin
            emit_port = d ? SIDE_L : SIDE_R;
            rel_we    = match_ok;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_lv <= 1'b0; out_rv <= 1'b0; out_cv <= 1'b0;
      out_lw <= '0;   out_rw <= '0;   out_cw <= '0;
      tab_v  <= '0;   tab_side <= '0; tab_inch <= '0;
      tab_src <= '0;  tab_dst <= '0;
      sink_v <= 1'b0; sink_side <= '0; sink_ch <= '0; sink_src <= '0;
    end else begin
      out_lv <= emit_v && (emit_port == SIDE_L);
      out_rv <= emit_v && (emit_port == SIDE_R);
      out_cv <= emit_v && (emit_port == SIDE_LOC);
      if (emit_v && emit_port == SIDE_L)   out_lw <= emit_word;
      if (emit_v && emit_port == SIDE_R)   out_rw <= emit_word;
      if (emit_v && emit_port == SIDE_LOC) out_cw <= emit_word;
      if (alloc_we) begin
        tab_v[d][free_idx]    <= 1'b1;
        tab_side[d][free_idx] <= in_side;
        tab_inch[d][free_idx] <= ch;
        tab_src[d][free_idx]  <= src;
        tab_dst[d][free_idx]  <= dst;
      end
      if (rel_we) tab_v[d][match_idx] <= 1'b0;
      if (sink_set) begin
        sink_v    <= 1'b1;
        sink_side <= in_side;
        sink_ch   <= ch;
        sink_src  <= src;
      end else if (sink_clr) begin
        sink_v <= 1'b0;
      end
    end
  end

  logic [CW-1:0]  fwd_ch;
  logic [NCH-1:0] low_mask;
  assign fwd_ch   = out_rw[0 +: CW];
  assign low_mask = (NCH'(1) << fwd_ch) - NCH'(1);

  AST_REQ_FWD_RESERVED: assert property (@(posedge clk) disable iff (rst)
    (out_rv && out_rw[CMD_W-1 -: 2] == OP_REQ) |-> tab_v[0][fwd_ch]); // R2
  AST_REQ_LOWEST_FREE: assert property (@(posedge clk) disable iff (rst)
    (out_rv && out_rw[CMD_W-1 -: 2] == OP_REQ) |-> ((tab_v[0] & low_mask) == low_mask)); // R2
  AST_SINGLE_EMIT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_lv, out_rv, out_cv})); // R8
endmodule

// File: rtl/xp_datanet.sv
`timescale 1ns/1ps
module xp_datanet
  import xp_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 8,
  localparam int CW = $clog2(NCH)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [1:0][NCH-1:0]         tab_v,
  input  logic [1:0][NCH-1:0][1:0]    tab_side,
  input  logic [1:0][NCH-1:0][CW-1:0] tab_inch,
  input  logic                        sink_v,
  input  logic [1:0]                  sink_side,
  input  logic [CW-1:0]               sink_ch,
  input  logic [NCH*DW-1:0]           lft_lane_in,
  input  logic [NCH*DW-1:0]           rgt_lane_in,
  input  logic [DW-1:0]               loc_tx_data,
  output logic [NCH*DW-1:0]           rgt_lane_out,
  output logic [NCH*DW-1:0]           lft_lane_out,
  output logic [DW-1:0]               loc_rx_data
);
  function automatic logic [DW-1:0] pick(input logic [1:0] side, input logic [CW-1:0] lane);
    case (side)
      SIDE_L:  return lft_lane_in[lane*DW +: DW];
      SIDE_R:  return rgt_lane_in[lane*DW +: DW];
      default: return loc_tx_data;
    endcase
  endfunction

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        rgt_lane_out[c*DW +: DW] <= '0;
        lft_lane_out[c*DW +: DW] <= '0;
      end else begin
        rgt_lane_out[c*DW +: DW] <= tab_v[0][c] ? pick(tab_side[0][c], tab_inch[0][c]) : '0;
        lft_lane_out[c*DW +: DW] <= tab_v[1][c] ? pick(tab_side[1][c], tab_inch[1][c]) : '0;
      end
    end

    AST_IDLE_LANE_ZERO: assert property (@(posedge clk) disable iff (rst)
      !tab_v[0][c] |=> (rgt_lane_out[c*DW +: DW] == '0)); // R9
  end

  always_ff @(posedge clk) begin
    if (rst) loc_rx_data <= '0;
    else     loc_rx_data <= sink_v ? pick(sink_side, sink_ch) : '0;
  end

  AST_RX_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !sink_v |=> (loc_rx_data == '0)); // R10
endmodule

// File: rtl/xp_crosspoint.sv
`timescale 1ns/1ps
module xp_crosspoint
  import xp_pkg::*;
#(
  parameter int NSLOT      = 8,
  parameter int NCH        = 4,
  parameter int DW         = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int MY_ID      = 3,
  localparam int SW    = $clog2(NSLOT),
  localparam int CW    = $clog2(NCH),
  localparam int CMD_W = 2 + 2*SW + CW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lft_cmd_valid,
  input  logic [CMD_W-1:0]  lft_cmd_word,
  output logic              lft_cmd_ready,
  input  logic              rgt_cmd_valid,
  input  logic [CMD_W-1:0]  rgt_cmd_word,
  output logic              rgt_cmd_ready,
  input  logic              loc_cmd_valid,
  input  logic [CMD_W-1:0]  loc_cmd_word,
  output logic              loc_cmd_ready,
  output logic              lft_out_valid,
  output logic [CMD_W-1:0]  lft_out_word,
  output logic              rgt_out_valid,
  output logic [CMD_W-1:0]  rgt_out_word,
  output logic              loc_out_valid,
  output logic [CMD_W-1:0]  loc_out_word,
  input  logic [NCH*DW-1:0] lft_lane_in,
  input  logic [NCH*DW-1:0] rgt_lane_in,
  input  logic [DW-1:0]     loc_tx_data,
  output logic [NCH*DW-1:0] rgt_lane_out,
  output logic [NCH*DW-1:0] lft_lane_out,
  output logic [DW-1:0]     loc_rx_data
);
  localparam int NSRC = 3;

  logic [NSRC-1:0]            push, full, empty, gnt;
  logic [NSRC-1:0][CMD_W-1:0] din, head;

  assign push = {loc_cmd_valid, rgt_cmd_valid, lft_cmd_valid};
  assign din  = {loc_cmd_word,  rgt_cmd_word,  lft_cmd_word};
  assign lft_cmd_ready = !full[SIDE_L];
  assign rgt_cmd_ready = !full[SIDE_R];
  assign loc_cmd_ready = !full[SIDE_LOC];

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    xp_cmd_fifo #(.W(CMD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst(rst), .push(push[s]), .din(din[s]),
      .pop(gnt[s]), .dout(head[s]), .full(full[s]), .empty(empty[s])
    );
  end

  xp_rr_arb #(.N(NSRC)) u_arb (
    .clk(clk), .rst(rst), .req(~empty), .gnt(gnt)
  );

  logic             sel_v;
  logic [1:0]       sel_side;
  logic [CMD_W-1:0] sel_word;

  always_comb begin
    sel_v    = |gnt;
    sel_side = SIDE_L;
    sel_word = head[0];
    for (int s = 0; s < NSRC; s++) begin
      if (gnt[s]) begin
        sel_side = 2'(s);
        sel_word = head[s];
      end
    end
  end

  logic [1:0][NCH-1:0]         tab_v;
  logic [1:0][NCH-1:0][1:0]    tab_side;
  logic [1:0][NCH-1:0][CW-1:0] tab_inch;
  logic                        sink_v;
  logic [1:0]                  sink_side;
  logic [CW-1:0]               sink_ch;

  xp_ctrl #(.NSLOT(NSLOT), .NCH(NCH), .MY_ID(MY_ID)) u_ctrl (
    .clk(clk), .rst(rst),
    .in_v(sel_v), .in_side(sel_side), .in_word(sel_word),
    .out_lv(lft_out_valid), .out_lw(lft_out_word),
    .out_rv(rgt_out_valid), .out_rw(rgt_out_word),
    .out_cv(loc_out_valid), .out_cw(loc_out_word),
    .tab_v(tab_v), .tab_side(tab_side), .tab_inch(tab_inch),
    .sink_v(sink_v), .sink_side(sink_side), .sink_ch(sink_ch)
  );

  xp_datanet #(.NCH(NCH), .DW(DW)) u_net (
    .clk(clk), .rst(rst),
    .tab_v(tab_v), .tab_side(tab_side), .tab_inch(tab_inch),
    .sink_v(sink_v), .sink_side(sink_side), .sink_ch(sink_ch),
    .lft_lane_in(lft_lane_in), .rgt_lane_in(rgt_lane_in), .loc_tx_data(loc_tx_data),
    .rgt_lane_out(rgt_lane_out), .lft_lane_out(lft_lane_out), .loc_rx_data(loc_rx_data)
  );
endmodule

// File: tb/xp_crosspoint_test.sv
`timescale 1ns/1ps
module xp_crosspoint_test;
  localparam int NSLOT = 8, NCH = 4, DW = 8, DEPTH = 4, MY_ID = 3;
  localparam int SW = $clog2(NSLOT), CW = $clog2(NCH), CMD_W = 2 + 2*SW + CW;
  localparam int VW = 2*(2 + CMD_W);
  localparam int NV = 15;
  localparam int P_L = 0, P_R = 1, P_C = 2;
  localparam int REQ = 0, REP = 1, CAN = 2, DES = 3;

  logic clk = 1'b0, rst = 1'b1;
  always #5 clk = ~clk;

  logic lcv = 0, rcv = 0, ccv = 0;
  logic [CMD_W-1:0] lcw = '0, rcw = '0, ccw = '0;
  logic lrdy, rrdy, crdy, lov, rov, cov;
  logic [CMD_W-1:0] low_, row_, cow_;
  logic [NCH*DW-1:0] lli = '0, rli = '0, rlo, llo;
  logic [DW-1:0] ltx = '0, lrx;

  xp_crosspoint #(.NSLOT(NSLOT), .NCH(NCH), .DW(DW), .FIFO_DEPTH(DEPTH), .MY_ID(MY_ID)) uut (
    .clk(clk), .rst(rst),
    .lft_cmd_valid(lcv), .lft_cmd_word(lcw), .lft_cmd_ready(lrdy),
    .rgt_cmd_valid(rcv), .rgt_cmd_word(rcw), .rgt_cmd_ready(rrdy),
    .loc_cmd_valid(ccv), .loc_cmd_word(ccw), .loc_cmd_ready(crdy),
    .lft_out_valid(lov), .lft_out_word(low_),
    .rgt_out_valid(rov), .rgt_out_word(row_),
    .loc_out_valid(cov), .loc_out_word(cow_),
    .lft_lane_in(lli), .rgt_lane_in(rli), .loc_tx_data(ltx),
    .rgt_lane_out(rlo), .lft_lane_out(llo), .loc_rx_data(lrx)
  );

  int checks = 0, errors = 0;

  function automatic logic [CMD_W-1:0] mkw(int op, int s, int d, int c);
    return {2'(op), SW'(s), SW'(d), CW'(c)};
  endfunction

  function automatic logic [VW-1:0] mkv(int ip, int op, int s, int d, int c,
                                        int ep, int eop, int es, int ed, int ec);
    return {2'(ip), mkw(op, s, d, c), 2'(ep), mkw(eop, es, ed, ec)};
  endfunction

  // {input port, command, expected output port, expected word}
  localparam logic [VW-1:0] VEC [NV] = '{
    mkv(P_C, REQ, 3, 6, 0, P_R, REQ, 3, 6, 0),  // R2 local opens to the right, lane 0
    mkv(P_L, REQ, 1, 5, 2, P_R, REQ, 1, 5, 1),  // R2 next lowest lane 1
    mkv(P_R, REQ, 6, 3, 1, P_R, REP, 6, 3, 1),  // R4 ends here, reply
    mkv(P_R, REQ, 7, 3, 0, P_R, CAN, 7, 3, 0),  // R4 receive lane busy
    mkv(P_R, REP, 3, 6, 0, P_C, REP, 3, 6, 0),  // R5 reply reaches sender
    mkv(P_L, REQ, 0, 7, 3, P_R, REQ, 0, 7, 2),  // R2 lane 2
    mkv(P_L, REQ, 2, 6, 0, P_R, REQ, 2, 6, 3),  // R2 lane 3
    mkv(P_L, REQ, 1, 4, 1, P_L, CAN, 1, 4, 1),  // R3 no free lane
    mkv(P_R, CAN, 0, 7, 0, P_L, CAN, 0, 7, 0),  // R6 release lane 2
    mkv(P_L, REQ, 2, 5, 0, P_R, REQ, 2, 5, 2),  // R6 lane 2 free again
    mkv(P_L, DES, 1, 5, 0, P_R, DES, 1, 5, 0),  // R7 forward, release lane 1
    mkv(P_R, DES, 6, 3, 0, P_C, DES, 6, 3, 0),  // R7 at destination
    mkv(P_R, REQ, 7, 3, 2, P_R, REP, 7, 3, 2),  // R7 receive lane freed
    mkv(P_R, REQ, 5, 0, 1, P_L, REQ, 5, 0, 0),  // R2 left-going side
    mkv(P_L, REP, 5, 0, 0, P_R, REP, 5, 0, 0)   // R5 reply toward right
  };

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(int p, logic [CMD_W-1:0] w);
    case (p)
      P_L: begin lcv = 1; lcw = w; end
      P_R: begin rcv = 1; rcw = w; end
      default: begin ccv = 1; ccw = w; end
    endcase
  endtask

  task automatic release_all();
    lcv = 0; rcv = 0; ccv = 0;
  endtask

  task automatic chk_out(string req, int ep, logic [CMD_W-1:0] ew);
    logic [2:0] ev;
    logic [CMD_W-1:0] aw;
    ev = 3'b1 << ep;
    aw = (ep == P_L) ? low_ : (ep == P_R) ? row_ : cow_;
    chk(req, {61'd0, cov, rov, lov}, {61'd0, ev});
    chk(req, 64'(aw), 64'(ew));
  endtask

  initial begin
    // watchdog
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 outputs", {61'd0, cov, rov, lov}, 64'd0);
    chk("R1 ready", {61'd0, crdy, rrdy, lrdy}, 64'd7);
    chk("R1 lanes", {rlo, llo}, 64'd0);
    chk("R1 rx", 64'(lrx), 64'd0);

    // vector table walk: command latency and routing (R2..R7)
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("vector %0d R2-R7 group", i);
      @(negedge clk);
      drive(int'(v[VW-1 -: 2]), v[CMD_W+2 +: CMD_W]);
      @(negedge clk);
      release_all();
      @(negedge clk);
      chk_out(tag, int'(v[CMD_W +: 2]), v[0 +: CMD_W]);
    end

    // R9 / R10 lane data through the reserved channels
    @(negedge clk);
    lli = 32'h0000_0011;
    rli = 32'h0066_7700;
    ltx = 8'hA5;
    @(negedge clk);
    chk("R9 right-going lanes", 64'(rlo), 64'h1111_00A5);
    chk("R9 left-going lanes", 64'(llo), 64'h0000_0077);
    chk("R10 local receive", 64'(lrx), 64'h66);
    ltx = 8'h3C;
    @(negedge clk);
    chk("R9 lane follows source", 64'(rlo[7:0]), 64'h3C);

    // R8 service order: last served was left, so right, local, left follow
    @(negedge clk);
    drive(P_L, mkw(REP, 6, 0, 0));
    drive(P_R, mkw(REP, 0, 6, 0));
    drive(P_C, mkw(REP, 3, 6, 0));
    @(negedge clk);
    release_all();
    @(negedge clk);
    chk_out("R8 first right", P_L, mkw(REP, 0, 6, 0));
    @(negedge clk);
    chk_out("R8 second local", P_C, mkw(REP, 3, 6, 0));
    @(negedge clk);
    chk_out("R8 third left", P_R, mkw(REP, 6, 0, 0));

    // R11 FIFO fill under contention
    begin
      int acc, outs;
      bit saw_full;
      acc = 0; outs = 0; saw_full = 0;
      for (int cyc = 0; cyc < 40; cyc++) begin
        @(negedge clk);
        outs += int'(lov) + int'(rov) + int'(cov);
        release_all();
        if (cyc < 10) begin
          if (!lrdy) saw_full = 1;
          if (lrdy) begin drive(P_L, mkw(REP, 6, 0, 0)); acc++; end
          if (rrdy) begin drive(P_R, mkw(REP, 0, 6, 0)); acc++; end
          if (crdy) begin drive(P_C, mkw(REP, 3, 6, 0)); acc++; end
        end
      end
      chk("R11 ready dropped when full", 64'(saw_full), 64'd1);
      chk("R11 one output per accepted command", 64'(outs), 64'(acc));
      chk("R11 ready back after drain", {61'd0, crdy, rrdy, lrdy}, 64'd7);
    end

    // R1 reset clears reservations
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 lanes cleared by reset", {rlo, llo}, 64'd0);
    chk("R1 rx cleared by reset", 64'(lrx), 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule